// File: doc/BRIEF.md
# Tester Per-Period Timing Generator

This block produces the timing markers a tester channel uses within each test period. A programmable period length, counted in clock ticks, sets when each period starts and ends. Three independent windows are derived from a running tick index. The data window covers the interval in which the driven value is a 1. The drive-enable window covers the interval in which the pin driver is switched on. The strobe window covers the interval in which the channel's comparators capture the device output.

Each window is defined by an opening tick and a closing tick. It is high while the tick index is at or above the opening tick and below the closing tick. The period length and all six edge values are captured together at each period boundary. A period that has already started keeps using the values it started with, even if the inputs change partway through. Downstream format and compare logic uses the one-cycle period-start pulse and the tick index to line up pattern data with each period.

Top module: `tester_timing_gen`

## Requirements
- R1: While reset is asserted, and in the cycle it is released, the period-start pulse, all three windows and the tick index are 0.
- R2: On the first clock edge after reset is released, a period begins. In every period, the tick index counts 0, 1, ..., L-1 and then restarts at 0, where L is the captured period length. The period-start output is high for exactly the cycles in which the tick index is 0.
- R3: A captured period length of 0 behaves as a length of 1: every cycle starts a new period with tick index 0.
- R4: The data output is high exactly when the tick index t satisfies rise <= t < fall, using the data rise and fall edges captured for the current period.
- R5: The drive-enable output is high exactly when on <= t < off, using the captured driver-on and driver-off edges.
- R6: The strobe output is high exactly when open <= t < close, using the captured strobe edges.
- R7: A window whose opening edge is equal to or greater than its closing edge never asserts.
- R8: The period length and edge inputs are sampled only on the clock edge that starts a period. Changes made during a period have no effect on the outputs until the next period begins.
- R9: A closing edge at or beyond the period length keeps the window high through the last tick of the period. The window is then evaluated again from tick 0 in the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| per_len_i | input | TICK_W | Period length in ticks (0 treated as 1) |
| data_rise_i | input | TICK_W | Tick at which the data window opens |
| data_fall_i | input | TICK_W | Tick at which the data window closes |
| drv_on_i | input | TICK_W | Tick at which the drive-enable window opens |
| drv_off_i | input | TICK_W | Tick at which the drive-enable window closes |
| stb_open_i | input | TICK_W | Tick at which the strobe window opens |
| stb_close_i | input | TICK_W | Tick at which the strobe window closes |
| period_start_o | output | 1 | One-cycle pulse in the first tick of each period |
| tick_o | output | TICK_W | Tick index within the current period |
| data_o | output | 1 | Data window |
| drv_en_o | output | 1 | Drive-enable window |
| strobe_o | output | 1 | Strobe window |

## Verification
The bench sweeps period lengths of 1 to 6 against every pair of edges from 0 to 7. This catches an off-by-one at either edge, which would show up as a window that is one tick too wide or too narrow. It also catches a design that asserts a window for one cycle when the opening edge equals the closing edge. One case changes the configuration partway through a period. A design that loads its settings on every cycle would then switch edges and length in the middle of that period, instead of waiting for the boundary. Other cases cover a zero period length and closing edges past the period end. The first would make a naive counter wrap through the full counter range. The second shows whether a window is cut off at the boundary and opens again correctly in the next period.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
    localparam int NUM_WIN = 3;

    typedef enum logic [1:0] {
        WIN_DATA   = 2'd0,
        WIN_DRIVE  = 2'd1,
        WIN_STROBE = 2'd2
    } win_e;
endpackage

// File: rtl/tg_period_ctr.sv
`timescale 1ns/1ps
module tg_period_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] tick_o,
    output logic         running_o,
    output logic         start_o,
    output logic         boundary_o
);
    typedef struct packed {
        logic         run;
        logic         start;
        logic [W-1:0] tick;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [W-1:0] last_tick;

    always_comb begin
        // Lengths 0 and 1 both give a last tick of 0
        last_tick  = (len_i == '0) ? '0 : len_i - W'(1);
        boundary_o = !ctr_q.run || (ctr_q.tick == last_tick);
        ctr_d       = ctr_q;
        ctr_d.start = 1'b0;
        if (boundary_o) begin
            ctr_d.run   = 1'b1;
            ctr_d.start = 1'b1;
            ctr_d.tick  = '0;
        end else begin
            ctr_d.tick  = ctr_q.tick + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign tick_o    = ctr_q.tick;
    assign running_o = ctr_q.run;
    assign start_o   = ctr_q.start;
endmodule

// File: rtl/tg_cfg_shadow.sv
`timescale 1ns/1ps
module tg_cfg_shadow #(
    parameter int W = 16,
    parameter int N = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [W-1:0]        len_i,
    input  logic [N-1:0][W-1:0] open_i,
    input  logic [N-1:0][W-1:0] close_i,
    output logic [W-1:0]        len_o,
    output logic [N-1:0][W-1:0] open_o,
    output logic [N-1:0][W-1:0] close_o
);
    typedef struct packed {
        logic [W-1:0]        len;
        logic [N-1:0][W-1:0] open;
        logic [N-1:0][W-1:0] close;
    } shd_t;

    shd_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (load_i) begin
            shd_d.len   = len_i;
            shd_d.open  = open_i;
            shd_d.close = close_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign len_o   = shd_q.len;
    assign open_o  = shd_q.open;
    assign close_o = shd_q.close;
endmodule

// File: rtl/tg_window.sv
`timescale 1ns/1ps
module tg_window #(
    parameter int W = 16
) (
    input  logic         run_i,
    input  logic [W-1:0] tick_i,
    input  logic [W-1:0] open_i,
    input  logic [W-1:0] close_i,
    output logic         win_o
);
    logic past_open, before_close;

    always_comb begin
        past_open    = (tick_i >= open_i);
        before_close = (tick_i < close_i);
        win_o        = run_i && past_open && before_close;
    end
endmodule

// File: rtl/tester_timing_gen.sv
`timescale 1ns/1ps
module tester_timing_gen #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] per_len_i,
    input  logic [TICK_W-1:0] data_rise_i,
    input  logic [TICK_W-1:0] data_fall_i,
    input  logic [TICK_W-1:0] drv_on_i,
    input  logic [TICK_W-1:0] drv_off_i,
    input  logic [TICK_W-1:0] stb_open_i,
    input  logic [TICK_W-1:0] stb_close_i,
    output logic              period_start_o,
    output logic [TICK_W-1:0] tick_o,
    output logic              data_o,
    output logic              drv_en_o,
    output logic              strobe_o
);
    import tg_pkg::*;
    localparam int N = NUM_WIN;

    logic [N-1:0][TICK_W-1:0] cfg_open, cfg_close;
    logic [N-1:0][TICK_W-1:0] sh_open, sh_close;
    logic [TICK_W-1:0]        sh_len;
    logic [N-1:0]             win_vec;
    logic                     boundary, running;

    always_comb begin
        cfg_open[int'(WIN_DATA)]    = data_rise_i;
        cfg_close[int'(WIN_DATA)]   = data_fall_i;
        cfg_open[int'(WIN_DRIVE)]   = drv_on_i;
        cfg_close[int'(WIN_DRIVE)]  = drv_off_i;
        cfg_open[int'(WIN_STROBE)]  = stb_open_i;
        cfg_close[int'(WIN_STROBE)] = stb_close_i;
    end

    tg_cfg_shadow #(.W(TICK_W), .N(N)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (boundary),
        .len_i   (per_len_i),
        .open_i  (cfg_open),
        .close_i (cfg_close),
        .len_o   (sh_len),
        .open_o  (sh_open),
        .close_o (sh_close)
    );

    // The counter's boundary decision uses the length of the period in progress
    tg_period_ctr #(.W(TICK_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .len_i      (sh_len),
        .tick_o     (tick_o),
        .running_o  (running),
        .start_o    (period_start_o),
        .boundary_o (boundary)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_win
        tg_window #(.W(TICK_W)) u_win (
            .run_i   (running),
            .tick_i  (tick_o),
            .open_i  (sh_open[gi]),
            .close_i (sh_close[gi]),
            .win_o   (win_vec[gi])
        );
    end

    assign data_o   = win_vec[int'(WIN_DATA)];
    assign drv_en_o = win_vec[int'(WIN_DRIVE)];
    assign strobe_o = win_vec[int'(WIN_STROBE)];
endmodule

// File: rtl/tg_checker.sv
`timescale 1ns/1ps
module tg_checker #(
    parameter int W = 16,
    parameter int N = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                period_start,
    input logic [W-1:0]        tick,
    input logic                boundary,
    input logic [W-1:0]        sh_len,
    input logic [N-1:0][W-1:0] sh_open,
    input logic [N-1:0][W-1:0] sh_close,
    input logic [N-1:0]        win_vec
);
    AST_START_TICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (tick == '0)); // R2

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick != '0) |-> (tick == $past(tick) + W'(1))); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(sh_len) && $stable(sh_open) && $stable(sh_close))); // R8

    for (genvar gi = 0; gi < N; gi++) begin : g_chk
        AST_EMPTY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
            (sh_open[gi] >= sh_close[gi]) |-> !win_vec[gi]); // R7

        AST_OPEN_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
            (period_start && sh_open[gi] == '0 && sh_close[gi] != '0) |-> win_vec[gi]); // R4
    end
endmodule

bind tester_timing_gen tg_checker #(.W(TICK_W), .N(tg_pkg::NUM_WIN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start_o),
    .tick         (tick_o),
    .boundary     (boundary),
    .sh_len       (sh_len),
    .sh_open      (sh_open),
    .sh_close     (sh_close),
    .win_vec      (win_vec)
);

// File: tb/sim_tester_timing_gen.sv
`timescale 1ns/1ps
module sim_tester_timing_gen;
    localparam int W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n;
    logic [W-1:0] per_len, d_rise, d_fall, e_on, e_off, s_open, s_close;
    logic         period_start, data_w, drv_w, stb_w;
    logic [W-1:0] tick;

    tester_timing_gen #(.TICK_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .per_len_i(per_len),
        .data_rise_i(d_rise), .data_fall_i(d_fall),
        .drv_on_i(e_on), .drv_off_i(e_off),
        .stb_open_i(s_open), .stb_close_i(s_close),
        .period_start_o(period_start), .tick_o(tick),
        .data_o(data_w), .drv_en_o(drv_w), .strobe_o(stb_w)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model, built from the requirements
    bit m_run, m_start;
    int m_tick, m_last;
    int a_open[3], a_close[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_start = 0; m_tick = 0;
        end else if (!m_run || m_tick == m_last) begin
            m_run = 1; m_start = 1; m_tick = 0;
            m_last = (per_len == 0) ? 0 : int'(per_len) - 1;
            a_open[0] = d_rise; a_close[0] = d_fall;
            a_open[1] = e_on;   a_close[1] = e_off;
            a_open[2] = s_open; a_close[2] = s_close;
        end else begin
            m_tick = m_tick + 1; m_start = 0;
        end
    end

    task automatic expect_val(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cycle(string ph);
        logic [2:0] got;
        string base[3];
        base[0] = "R4"; base[1] = "R5"; base[2] = "R6";
        @(negedge clk);
        got = {stb_w, drv_w, data_w};
        expect_val(ph == "" ? "R2" : ph, "period_start", int'(period_start), int'(m_start));
        expect_val(ph == "" ? "R2" : ph, "tick", int'(tick), m_tick);
        for (int i = 0; i < 3; i++) begin
            bit exp_w;
            string req;
            exp_w = m_run && (m_tick >= a_open[i]) && (m_tick < a_close[i]);
            req = (ph != "") ? ph : ((a_open[i] >= a_close[i]) ? "R7" : base[i]);
            expect_val(req, $sformatf("window%0d", i), int'(got[i]), int'(exp_w));
        end
    endtask

    task automatic set_cfg(int len, int dr, int df, int eo, int ef, int so, int sc);
        per_len = W'(len); d_rise = W'(dr); d_fall = W'(df);
        e_on = W'(eo); e_off = W'(ef); s_open = W'(so); s_close = W'(sc);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        set_cfg(4, 0, 5, 0, 5, 0, 5);
        // R1: quiet in reset
        for (int i = 0; i < 3; i++) cycle("R1");
        rst_n = 1'b1;
        cycle("R1");
        for (int i = 0; i < 12; i++) cycle("");

        // Scaled test-period example: long period, short drive, late strobe
        set_cfg(200, 0, 10, 0, 10, 190, 195);
        for (int i = 0; i < 410; i++) cycle("");

        // R3: zero length acts as one
        set_cfg(0, 0, 1, 1, 2, 0, 3);
        for (int i = 0; i < 210; i++) cycle(i < 205 ? "" : "R3");

        // R9: closing edge past the period end
        set_cfg(4, 2, 10, 0, 200, 3, 9);
        for (int i = 0; i < 14; i++) cycle(i < 5 ? "" : "R9");

        // R8: change mid-period, must wait for the boundary
        set_cfg(8, 1, 6, 2, 5, 4, 7);
        while (!(m_run && m_tick == 3 && a_close[0] == 6 && m_last == 7)) cycle("");
        set_cfg(3, 0, 2, 1, 3, 2, 3);
        for (int i = 0; i < 12; i++) cycle("R8");

        // Sweep over period lengths and edge pairs (R4 R5 R6 R7)
        for (int len = 1; len <= 6; len++)
            for (int s = 0; s < 8; s++)
                for (int e = 0; e < 8; e++) begin
                    set_cfg(len, s, e, e, s, s, (e + 1) % 8);
                    for (int k = 0; k < 2 * len + 2; k++) cycle("");
                end

        done = 1;
        report();
        $finish;
    end
endmodule